// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside an SDRAM command sequencer. It holds the burst-related fields of the mode word and, for every read or write burst, produces the column address of each beat. A burst may start at any column. The low column bits walk either in sequential order or in interleaved (XOR) order inside an aligned window. The higher bits stay fixed. A full-page setting walks all columns of the row and keeps wrapping until it is told to stop.

A mode load latches burst length, wrap order, read latency and a single-write option. With single-write set, write bursts are one beat long and read bursts keep the programmed length. A code that is not defined sets an error flag, and the settings in force stay unchanged. A burst ends after its last beat, on a terminate strobe, or when a new burst starts. When the clock enable was low at the previous edge, the whole block freezes for that edge, and commands presented at that edge are ignored.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, valid_o, last_o and mode_err_o are 0, col_o is 0, cas_lat_o is 2, and the burst setting is length 1 with sequential order and single-write off.
- R2: A mode load decodes bits [2:0] as the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page (256 beats).
- R3: With mode bit 3 at 0 (sequential), beat k of a burst of length BL that starts at column S has the address (S with its low log2(BL) bits cleared) plus ((S + k) mod BL).
- R4: With mode bit 3 at 1 (interleaved), beat k has the address S XOR (k mod BL).
- R5: A full-page burst never raises last_o. It steps through the columns with wrap from 255 to 0 and keeps running until it is terminated or replaced.
- R6: last_o is 1 exactly on the final beat of a finite burst. valid_o falls in the cycle after that beat unless a new burst starts.
- R7: stop_i accepted during a burst makes valid_o 0 in the next cycle.
- R8: start_i accepted during a burst abandons the old burst, and the next cycle shows beat 0 of the new burst.
- R9: With mode bit 9 set, a write burst (write_i=1) lasts exactly one beat with last_o=1. A read burst keeps the programmed length.
- R10: Mode bits [6:4] give the read latency: 010 gives cas_lat_o=2 and 011 gives cas_lat_o=3.
- R11: A load with a reserved length code (100, 101, 110), with full page combined with interleave, or with a reserved latency code sets mode_err_o and keeps every previous setting. A legal load clears mode_err_o.
- R12: If cke_i was 0 at the previous clock edge, the current edge changes no state: column, valid, last and beat all hold, and start, stop and mode load presented at that edge are ignored.
- R13: A start accepted at an edge shows start_col_i on col_o with valid_o=1 right after that edge. Each further accepted edge advances the burst by one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable. When it is low, the following edge is frozen |
| mode_load_i | input | 1 | Load mode_data_i into the burst settings |
| mode_data_i | input | MODE_W | Mode word: [2:0] length, [3] order, [6:4] latency, [9] single-write |
| start_i | input | 1 | Begin a burst |
| start_col_i | input | COL_W | First column of the burst |
| write_i | input | 1 | Burst is a write |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Current beat column, 0 when idle |
| valid_o | output | 1 | A burst beat is present |
| last_o | output | 1 | Current beat is the final one |
| cas_lat_o | output | 2 | Decoded read latency (2 or 3) |
| mode_err_o | output | 1 | Last mode load carried a reserved code |

## Verification
Each result is due one edge after the edge that accepts its command. A start, stop or mode load presented before edge N shows up after edge N, but only if cke_i was high at edge N-1. A stalled edge pushes every later beat back by one cycle. The bench drives inputs on the falling edge and steps a reference model once per rising edge. The model carries its own copy of the previous-edge enable, and the outputs are compared on the next falling edge. This way every comparison falls one register stage after the stimulus, and the stall rule is modelled explicitly.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int LEN_LSB   = 0;
  localparam int LEN_W     = 3;
  localparam int ORDER_BIT = 3;
  localparam int LAT_LSB   = 4;
  localparam int LAT_W     = 3;
  localparam int SWR_BIT   = 9;

  localparam logic [LEN_W-1:0] LEN_FULL = 3'b111;
  localparam logic [LAT_W-1:0] LAT_TWO  = 3'b010;
  localparam logic [LAT_W-1:0] LAT_THREE = 3'b011;

  typedef struct packed {
    logic [1:0] len_log2;
    logic       full;
    logic       ilv;
    logic       lat3;
    logic       single_wr;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_RESET = '{len_log2: 2'd0, full: 1'b0, ilv: 1'b0,
                                       lat3: 1'b0, single_wr: 1'b0};
endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  output burst_cfg_t        cfg_o,
  output logic              err_o
);
  logic [LEN_W-1:0] len_code;
  logic [LAT_W-1:0] lat_code;
  logic             len_ok, lat_ok;
  burst_cfg_t       cfg_q, cfg_d;
  logic             err_q;

  assign len_code = mode_i[LEN_LSB +: LEN_W];
  assign lat_code = mode_i[LAT_LSB +: LAT_W];

  always_comb begin
    cfg_d           = cfg_q;
    cfg_d.ilv       = mode_i[ORDER_BIT];
    cfg_d.single_wr = mode_i[SWR_BIT];
    cfg_d.len_log2  = len_code[1:0];
    cfg_d.full      = 1'b0;
    len_ok          = 1'b0;
    if (len_code[2] == 1'b0) begin
      len_ok = 1'b1;
    end else if (len_code == LEN_FULL) begin
      cfg_d.full     = 1'b1;
      cfg_d.len_log2 = 2'd0;
      len_ok         = !mode_i[ORDER_BIT];  // full page only wraps sequentially
    end
    lat_ok     = (lat_code == LAT_TWO) || (lat_code == LAT_THREE);
    cfg_d.lat3 = (lat_code == LAT_THREE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RESET;
      err_q <= 1'b0;
    end else if (en_i && load_i) begin
      if (len_ok && lat_ok) begin
        cfg_q <= cfg_d;
        err_q <= 1'b0;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;
endmodule

// File: rtl/colgen_burst_ctr.sv
module colgen_burst_ctr
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             stop_i,
  input  burst_cfg_t       cfg_i,
  output logic             valid_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o
);
  logic             single;
  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic             valid_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             last;

  assign single = write_i && cfg_i.single_wr;
  assign full_d = cfg_i.full && !single;

  always_comb begin
    if (single)          mask_d = '0;
    else if (cfg_i.full) mask_d = '1;
    else                 mask_d = (COL_W'(1) << cfg_i.len_log2) - COL_W'(1);
  end

  assign last = valid_q && !full_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
    end else if (en_i) begin
      if (start_i) begin
        valid_q <= 1'b1;
        base_q  <= start_col_i;
        beat_q  <= '0;
        mask_q  <= mask_d;
        full_q  <= full_d;
        ilv_q   <= cfg_i.ilv;
      end else if (stop_i || last) begin
        valid_q <= 1'b0;
      end else if (valid_q) begin
        beat_q <= beat_q + COL_W'(1);
      end
    end
  end

  assign valid_o = valid_q;
  assign last_o  = last;
  assign base_o  = base_q;
  assign beat_o  = beat_q;
  assign mask_o  = mask_q;
  assign ilv_o   = ilv_q;
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_sum;
  assign seq_sum = base_i + beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = !mask_i[b] ? base_i[b]
                    : (ilv_i ? (base_i[b] ^ beat_i[b]) : seq_sum[b]);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_data_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              write_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic [1:0]        cas_lat_o,
  output logic              mode_err_o
);
  logic             cke_q;
  burst_cfg_t       cfg;
  logic             valid, last, ilv;
  logic [COL_W-1:0] base, beat, mask, col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  colgen_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cke_q),
    .load_i (mode_load_i),
    .mode_i (mode_data_i),
    .cfg_o  (cfg),
    .err_o  (mode_err_o)
  );

  colgen_burst_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cke_q),
    .start_i     (start_i),
    .write_i     (write_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .cfg_i       (cfg),
    .valid_o     (valid),
    .last_o      (last),
    .base_o      (base),
    .beat_o      (beat),
    .mask_o      (mask),
    .ilv_o       (ilv)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (ilv),
    .col_o  (col)
  );

  assign col_o     = valid ? col : '0;
  assign valid_o   = valid;
  assign last_o    = last;
  assign cas_lat_o = cfg.lat3 ? 2'd3 : 2'd2;
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker
  import colgen_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_i,
  input logic              mode_load_i,
  input logic [MODE_W-1:0] mode_data_i,
  input logic              start_i,
  input logic [COL_W-1:0]  start_col_i,
  input logic              stop_i,
  input logic [COL_W-1:0]  col_o,
  input logic              valid_o,
  input logic              last_o,
  input logic              mode_err_o
);
  logic ck1, ck2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck1 <= 1'b1;
      ck2 <= 1'b1;
    end else begin
      ck1 <= cke_i;
      ck2 <= ck1;
    end
  end

  AST_LAST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);  // R6

  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck1 && last_o && !start_i |=> !valid_o);  // R6

  AST_START_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck1 && start_i |=> valid_o && (col_o == $past(start_col_i)));  // R13

  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck1 && stop_i && !start_i |=> !valid_o);  // R7

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ck2 |-> $stable(col_o) && $stable(valid_o) && $stable(last_o) && $stable(mode_err_o));  // R12

  AST_BAD_LEN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck1 && mode_load_i && mode_data_i[LEN_LSB+2] && (mode_data_i[LEN_LSB +: LEN_W] != LEN_FULL)
    |=> mode_err_o);  // R11

  AST_IDLE_COL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> col_o == '0);  // R1
endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cke_i       (cke_i),
  .mode_load_i (mode_load_i),
  .mode_data_i (mode_data_i),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .mode_err_o  (mode_err_o)
);

// File: tb/sdram_burst_colgen_tb.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb;
  localparam real CLK_NS = 8.0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_i = 1'b1;
  logic        mode_load_i = 1'b0;
  logic [11:0] mode_data_i = '0;
  logic        start_i = 1'b0;
  logic [7:0]  start_col_i = '0;
  logic        write_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [7:0]  col_o;
  logic        valid_o, last_o, mode_err_o;
  logic [1:0]  cas_lat_o;

  always #(CLK_NS/2) clk_i = ~clk_i;

  sdram_burst_colgen u_dut (
    .clk_i, .rst_ni, .cke_i, .mode_load_i, .mode_data_i, .start_i,
    .start_col_i, .write_i, .stop_i, .col_o, .valid_o, .last_o,
    .cas_lat_o, .mode_err_o
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  int m_len = 1, m_full = 0, m_ilv = 0, m_lat = 2, m_sw = 0, m_err = 0;
  int m_valid = 0, m_base = 0, m_beat = 0, m_bl = 1, m_bfull = 0, m_bilv = 0;
  bit cke_d = 1'b1;

  function automatic int exp_col();
    int msk;
    if (!m_valid) return 0;
    msk = m_bl - 1;
    if (m_bilv) return (m_base ^ (m_beat & msk)) & 255;
    return ((m_base & ~msk) | ((m_base + m_beat) & msk)) & 255;
  endfunction

  function automatic bit exp_last();
    return (m_valid != 0) && !m_bfull && (m_beat == m_bl - 1);
  endfunction

  task automatic model_step(bit st, int c, bit wr, bit sp, bit ld, int md);
    bit lst;
    int lc, lt, il, ok, nlen, nfull;
    lst = exp_last();
    if (st) begin
      m_valid = 1; m_base = c; m_beat = 0; m_bilv = m_ilv;
      if (wr && m_sw) begin m_bl = 1; m_bfull = 0; end
      else begin m_bl = m_len; m_bfull = m_full; end
    end else if (sp || lst) m_valid = 0;
    else if (m_valid) m_beat = (m_beat + 1) % 256;
    if (ld) begin
      lc = md & 7; il = (md >> 3) & 1; lt = (md >> 4) & 7;
      ok = 1; nfull = 0; nlen = 1;
      if (lc < 4) nlen = 1 << lc;
      else if (lc == 7) begin nlen = 256; nfull = 1; if (il) ok = 0; end
      else ok = 0;
      if (lt != 2 && lt != 3) ok = 0;
      if (ok) begin
        m_len = nlen; m_full = nfull; m_ilv = il; m_lat = lt; m_sw = (md >> 9) & 1; m_err = 0;
      end else m_err = 1;
    end
  endtask

  task automatic check_outs();
    int ec;
    bit el;
    ec = exp_col(); el = exp_last();
    n_chk++;
    if (valid_o !== (m_valid != 0) || last_o !== el || col_o !== ec[7:0] ||
        mode_err_o !== (m_err != 0) || cas_lat_o !== m_lat[1:0]) begin
      n_fail++;
      $display("FAIL %s: act v=%0b l=%0b col=%0d err=%0b cl=%0d exp v=%0d l=%0b col=%0d err=%0d cl=%0d",
               cur_req, valid_o, last_o, col_o, mode_err_o, cas_lat_o,
               m_valid, el, ec, m_err, m_lat);
    end
  endtask

  // called at a falling edge; drives, steps one rising edge, checks at next falling edge
  task automatic cyc(bit st, int c, bit wr, bit sp, bit ck, bit ld, int md);
    start_i = st; start_col_i = c[7:0]; write_i = wr; stop_i = sp;
    cke_i = ck; mode_load_i = ld; mode_data_i = md[11:0];
    @(posedge clk_i);
    if (cke_d) model_step(st, c, wr, sp, ld, md);
    cke_d = ck;
    @(negedge clk_i);
    check_outs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic load(int md);
    cyc(0, 0, 0, 0, 1, 1, md);
  endtask

  task automatic burst(int c, bit wr, int n);
    cyc(1, c, wr, 0, 1, 0, 0);
    idle(n);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C01));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cur_req = "R1"; check_outs(); idle(2);
    burst(8'h47, 0, 2);                 // default length 1

    cur_req = "R3"; load(12'h022); burst(8'h1D, 0, 5);   // 1D 1E 1F 1C
    cur_req = "R4"; load(12'h02A); burst(8'h1D, 0, 5);   // 1D 1C 1F 1E
    cur_req = "R2"; load(12'h023); burst(8'h35, 0, 9);
    load(12'h02B); burst(8'h35, 1, 9);
    load(12'h021); burst(8'hFF, 0, 3);
    load(12'h020); burst(8'h80, 0, 2);
    cur_req = "R10"; load(12'h032); idle(1); load(12'h022); idle(1);
    cur_req = "R6"; load(12'h022); burst(8'h02, 0, 4);
    cur_req = "R5"; load(12'h027); burst(8'hFE, 0, 262);
    cyc(0, 0, 0, 1, 1, 0, 0); idle(2);
    cur_req = "R7"; load(12'h023); cyc(1, 8'h10, 0, 0, 1, 0, 0); idle(2);
    cyc(0, 0, 0, 1, 1, 0, 0); idle(2);
    cur_req = "R8"; cyc(1, 8'h50, 0, 0, 1, 0, 0); idle(3);
    cyc(1, 8'hA3, 1, 0, 1, 0, 0); idle(9);
    cur_req = "R9"; load(12'h222); burst(8'h44, 1, 3); burst(8'h44, 0, 5);
    load(12'h2A7); idle(1); load(12'h227); burst(8'h12, 1, 2);
    cur_req = "R11"; load(12'h023);
    load(12'h02F); idle(1); burst(8'h08, 0, 9);
    load(12'h024); load(12'h026); load(12'h042); load(12'h012); idle(1);
    load(12'h032); idle(1);
    cur_req = "R12"; load(12'h022);
    cyc(1, 8'h61, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0); cyc(1, 8'h99, 0, 1, 1, 1, 12'h02F); idle(4);
    cyc(0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 8'h20, 0, 0, 1, 0, 0); idle(5);
    cur_req = "R13"; burst(8'h7F, 0, 1);

    cur_req = "R3";
    for (int it = 0; it < 350; it++) begin
      int lc, md, n;
      if ($urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 6))
          0: lc = 0; 1: lc = 1; 2: lc = 2; 3: lc = 3; 4: lc = 7; 5: lc = 7;
          default: lc = $urandom_range(4, 6);
        endcase
        md = lc | ($urandom_range(0, 1) << 3) | ($urandom_range(2, 3) << 4) |
             ($urandom_range(0, 1) << 9);
        if ($urandom_range(0, 9) == 0) md = md ^ (4 << 4);
        cur_req = "R11"; load(md);
      end
      cur_req = m_ilv ? "R4" : "R3";
      cyc(1, $urandom_range(0, 255), $urandom_range(0, 1), 0, 1, 0, 0);
      n = $urandom_range(1, 12);
      for (int k = 0; k < n; k++) begin
        int r;
        r = $urandom_range(0, 19);
        cur_req = (r < 4) ? "R12" : (r == 4) ? "R7" : (r == 5) ? "R8" : "R6";
        cyc(r == 5, $urandom_range(0, 255), $urandom_range(0, 1), r == 4, r >= 4, 0, 0);
      end
    end
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule